// File: doc/BRIEF.md
# Lockable Management-Memory Window Decoder

This block keeps the control word for a relocatable memory window reserved for system-management code and, in the same cycle, decides where each memory request goes: to DRAM or to the compatibility I/O bus. The control word holds the window base (64 KB granular), its size code, and four control bits: enable, open, code-only and lock. A small synchronous port with byte enables writes the word, and a registered read returns it.

A request gives a 32-bit address, a code-fetch flag and a flag saying whether the requesting processor is in management mode. When the address falls inside an enabled window, the control bits and the requester's attributes choose the destination. Any other request takes the ordinary route, which is DRAM below the top-of-memory limit input and the compatibility bus at or above it. Once the lock bit is written, the window is forced closed and the open and lock bits cannot change until reset. The block also flags a base that is not naturally aligned to the window size, and a contradictory setting of the control bits.

Top module: `smw_decoder`

## Requirements
- R1: After reset the control word reads 0x0000000A: base field 000Ah, size code 0, and enable, open, code-only and lock all 0.
- R2: Bits 31:28 and 19:16 of the control word always read 0, and writes to them have no effect.
- R3: Write byte enable n updates only byte lane n. Lanes 0 and 1 hold the base in bits 15:0. Lane 2 holds the size code in bits 23:20. Lane 3 holds enable (bit 27), open (bit 26), code-only (bit 25) and lock (bit 24). A read returns, one cycle after the read strobe, the word as it stood before any write in that same cycle.
- R4: A lane-3 write with bit 24 set sets lock and clears open in the same write, whatever bit 26 of that write holds.
- R5: While lock is set, writes cannot change lock or open until reset. Base, size code, enable and code-only stay writable.
- R6: A request hits when enable is 1, base×64 KB ≤ address < base×64 KB + (size code + 1)×64 KB, and the window end is at or below the top-of-memory limit. Size code Fh gives 1 MB.
- R7: A request that misses goes to DRAM when its address is below the top-of-memory limit, and to the compatibility bus otherwise.
- R8: With open 0 and code-only 0, a hit goes to DRAM exactly when the requester is in management mode.
- R9: With open 0 and code-only 1, a hit goes to DRAM only for a code fetch by a requester in management mode.
- R10: With open 1 and code-only 0, every hit goes to DRAM.
- R11: When open and code-only are both 1, the illegal-setting output is 1 and every hit goes to the compatibility bus.
- R12: The misalignment output is 1 when the base is not a multiple of the smallest power of two (in 64 KB units) that is at least size code + 1.
- R13: With enable 0 the hit output stays 0 and every request follows the R7 route.
- On the ports: rsp_dram 1 means DRAM, 0 means the compatibility bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_wr_en | input | 1 | Control-word write strobe |
| cfg_wr_be | input | 4 | Byte enables for the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_en | input | 1 | Control-word read strobe |
| cfg_rd_data | output | 32 | Registered read data |
| req_addr | input | 32 | Request address |
| req_code | input | 1 | Request is a code fetch |
| req_smm | input | 1 | Requester is in management mode |
| tom_limit | input | 32 | Top-of-memory limit, exclusive |
| rsp_hit | output | 1 | Request falls inside the active window |
| rsp_dram | output | 1 | Route: 1 DRAM, 0 compatibility bus |
| cfg_illegal | output | 1 | Open and code-only are both set |
| cfg_misalign | output | 1 | Base is not aligned to the window size |

## Verification
On every cycle the assertions check how a hit is routed in each control mode, how a miss is routed against the top-of-memory limit, that no hit occurs while the window is disabled, that a hit address is not below the base, that the reserved bits read zero, and that lock is sticky and freezes open. The exact window edges, the top-of-memory clipping, the size-dependent alignment flag, byte-lane isolation and the read-back values after lock and after a second reset come from the bench's scenarios. There, a behavioural model and hand-computed expectations are checked against the ports.

// File: rtl/smw_pkg.sv
package smw_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_LOG2  = 16;
  localparam int SIZE_W     = 4;
  localparam int REG_W      = 32;
  localparam int BE_W       = REG_W / 8;
  localparam int BASE_W     = ADDR_W - GRAN_LOG2;
  localparam int BASE_BYTES = BASE_W / 8;

  // control-word field positions (software-visible layout)
  localparam int BASE_LSB  = 0;
  localparam int SIZE_LSB  = 20;
  localparam int LOCK_BIT  = 24;
  localparam int CODE_BIT  = 25;
  localparam int OPEN_BIT  = 26;
  localparam int EN_BIT    = 27;
  localparam int CTRL_LANE = 3;
  localparam int SIZE_LANE = 2;

  localparam logic [BASE_W-1:0] RST_BASE = BASE_W'(16'h000A);

  typedef struct packed {
    logic              enable;
    logic              open;
    logic              code_only;
    logic              lock;
    logic [SIZE_W-1:0] size;
    logic [BASE_W-1:0] base;
  } smw_cfg_t;

  typedef enum logic {
    RT_COMPAT = 1'b0,
    RT_DRAM   = 1'b1
  } smw_route_e;
endpackage

// File: rtl/smw_ctrl_reg.sv
module smw_ctrl_reg
  import smw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output smw_cfg_t         cfg
);
  smw_cfg_t         cfg_q, cfg_d;
  logic             cfg_we;
  logic [REG_W-1:0] img;

  assign cfg_we = wr_en && (|wr_be);

  // next-state of the control word
  always_comb begin
    cfg_d = cfg_q;
    for (int b = 0; b < BASE_BYTES; b++) begin
      if (wr_be[b]) cfg_d.base[8*b +: 8] = wr_data[BASE_LSB + 8*b +: 8];
    end
    if (wr_be[SIZE_LANE]) cfg_d.size = wr_data[SIZE_LSB +: SIZE_W];
    if (wr_be[CTRL_LANE]) begin
      cfg_d.enable    = wr_data[EN_BIT];
      cfg_d.code_only = wr_data[CODE_BIT];
      if (!cfg_q.lock) begin
        if (wr_data[LOCK_BIT]) begin
          cfg_d.lock = 1'b1;
          cfg_d.open = 1'b0;
        end else begin
          cfg_d.open = wr_data[OPEN_BIT];
        end
      end
    end
  end

  // software view; unlisted bits are zero
  always_comb begin
    img                         = '0;
    img[BASE_LSB +: BASE_W]     = cfg_q.base;
    img[SIZE_LSB +: SIZE_W]     = cfg_q.size;
    img[LOCK_BIT]               = cfg_q.lock;
    img[CODE_BIT]               = cfg_q.code_only;
    img[OPEN_BIT]               = cfg_q.open;
    img[EN_BIT]                 = cfg_q.enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{enable: 1'b0, open: 1'b0, code_only: 1'b0, lock: 1'b0,
                 size: '0, base: RST_BASE};
      rd_data <= '0;
    end else begin
      if (cfg_we) cfg_q   <= cfg_d;
      if (rd_en)  rd_data <= img;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/smw_window_match.sv
module smw_window_match
  import smw_pkg::*;
(
  input  smw_cfg_t          cfg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] tom_limit,
  output logic              hit,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0]  win_lo, win_span, win_hi, addr_x, tom_x;
  logic [SIZE_W-1:0] mask;

  // smallest power-of-two unit count covering the size, minus one
  function automatic logic [SIZE_W-1:0] align_mask(input logic [SIZE_W-1:0] code);
    logic [SIZE_W:0] units;
    logic [SIZE_W:0] p;
    units = {1'b0, code} + (SIZE_W+1)'(1);
    p     = (SIZE_W+1)'(1);
    for (int i = 0; i < SIZE_W; i++) begin
      if (p < units) p = p << 1;
    end
    return SIZE_W'(p - (SIZE_W+1)'(1));
  endfunction

  always_comb begin
    win_lo   = {1'b0, cfg.base, {GRAN_LOG2{1'b0}}};
    win_span = (EXT_W'(cfg.size) + EXT_W'(1)) << GRAN_LOG2;
    win_hi   = win_lo + win_span;
    addr_x   = {1'b0, req_addr};
    tom_x    = {1'b0, tom_limit};
    hit      = cfg.enable && (addr_x >= win_lo) && (addr_x < win_hi) && (win_hi <= tom_x);
    mask     = align_mask(cfg.size);
    misalign = |(cfg.base[SIZE_W-1:0] & mask);
  end
endmodule

// File: rtl/smw_route_sel.sv
module smw_route_sel
  import smw_pkg::*;
(
  input  smw_cfg_t          cfg,
  input  logic              hit,
  input  logic              req_code,
  input  logic              req_smm,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] tom_limit,
  output smw_route_e        route,
  output logic              illegal
);
  logic below_tom;

  assign below_tom = req_addr < tom_limit;
  assign illegal   = cfg.open && cfg.code_only;

  always_comb begin
    route = below_tom ? RT_DRAM : RT_COMPAT;
    if (hit) begin
      unique case ({cfg.open, cfg.code_only})
        2'b11:   route = RT_COMPAT;
        2'b10:   route = RT_DRAM;
        2'b01:   route = (req_smm && req_code) ? RT_DRAM : RT_COMPAT;
        default: route = req_smm ? RT_DRAM : RT_COMPAT;
      endcase
    end
  end
endmodule

// File: rtl/smw_decoder.sv
module smw_decoder
  import smw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [BE_W-1:0]   cfg_wr_be,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              cfg_rd_en,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_code,
  input  logic              req_smm,
  input  logic [ADDR_W-1:0] tom_limit,
  output logic              rsp_hit,
  output logic              rsp_dram,
  output logic              cfg_illegal,
  output logic              cfg_misalign
);
  smw_cfg_t   cfg_q;
  smw_route_e route;

  smw_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_be   (cfg_wr_be),
    .wr_data (cfg_wr_data),
    .rd_en   (cfg_rd_en),
    .rd_data (cfg_rd_data),
    .cfg     (cfg_q)
  );

  smw_window_match u_match (
    .cfg       (cfg_q),
    .req_addr  (req_addr),
    .tom_limit (tom_limit),
    .hit       (rsp_hit),
    .misalign  (cfg_misalign)
  );

  smw_route_sel u_route (
    .cfg       (cfg_q),
    .hit       (rsp_hit),
    .req_code  (req_code),
    .req_smm   (req_smm),
    .req_addr  (req_addr),
    .tom_limit (tom_limit),
    .route     (route),
    .illegal   (cfg_illegal)
  );

  assign rsp_dram = (route == RT_DRAM);
endmodule

// File: rtl/smw_decoder_chk.sv
module smw_decoder_chk
  import smw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input smw_cfg_t          cfg,
  input logic [REG_W-1:0]  cfg_rd_data,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_code,
  input logic              req_smm,
  input logic [ADDR_W-1:0] tom_limit,
  input logic              rsp_hit,
  input logic              rsp_dram,
  input logic              cfg_illegal
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[19:16] == 4'h0) && (cfg_rd_data[31:28] == 4'h0));

  a_r4_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg.lock) |-> !cfg.open);

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lock |=> (cfg.lock && $stable(cfg.open)));

  a_r6_hit_above_base: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (req_addr[ADDR_W-1:GRAN_LOG2] >= cfg.base));

  a_r7_miss_route: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_dram == (req_addr < tom_limit)));

  a_r8_closed_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !cfg.open && !cfg.code_only) |-> (rsp_dram == req_smm));

  a_r9_code_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !cfg.open && cfg.code_only) |-> (rsp_dram == (req_smm && req_code)));

  a_r10_open_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && cfg.open && !cfg.code_only) |-> rsp_dram);

  a_r11_illegal_compat: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && cfg_illegal) |-> !rsp_dram);

  a_r13_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.enable |-> !rsp_hit);
endmodule

bind smw_decoder smw_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg         (cfg_q),
  .cfg_rd_data (cfg_rd_data),
  .req_addr    (req_addr),
  .req_code    (req_code),
  .req_smm     (req_smm),
  .tom_limit   (tom_limit),
  .rsp_hit     (rsp_hit),
  .rsp_dram    (rsp_dram),
  .cfg_illegal (cfg_illegal)
);

// File: tb/smw_decoder_bench.sv
`timescale 1ns/1ps
module smw_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_rd_en = 1'b0;
  logic [31:0] cfg_rd_data;
  logic [31:0] req_addr = '0;
  logic        req_code = 1'b0;
  logic        req_smm = 1'b0;
  logic [31:0] tom_limit = 32'h1000_0000;
  logic        rsp_hit, rsp_dram, cfg_illegal, cfg_misalign;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smw_decoder u_smw_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_data(cfg_rd_data),
    .req_addr(req_addr), .req_code(req_code), .req_smm(req_smm),
    .tom_limit(tom_limit),
    .rsp_hit(rsp_hit), .rsp_dram(rsp_dram),
    .cfg_illegal(cfg_illegal), .cfg_misalign(cfg_misalign)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 32'h0000_000A;
      m_rd  = 32'h0;
    end else begin
      if (cfg_rd_en) m_rd = m_reg;
      if (cfg_wr_en) begin
        if (cfg_wr_be[0]) m_reg[7:0]   = cfg_wr_data[7:0];
        if (cfg_wr_be[1]) m_reg[15:8]  = cfg_wr_data[15:8];
        if (cfg_wr_be[2]) m_reg[23:20] = cfg_wr_data[23:20];
        if (cfg_wr_be[3]) begin
          m_reg[27] = cfg_wr_data[27];
          m_reg[25] = cfg_wr_data[25];
          if (m_reg[24] == 1'b0) begin
            if (cfg_wr_data[24]) begin
              m_reg[24] = 1'b1;
              m_reg[26] = 1'b0;
            end else begin
              m_reg[26] = cfg_wr_data[26];
            end
          end
        end
      end
    end
  end

  task automatic model_route(output bit hit, output bit dram, output bit ill,
                             output bit mis, output string mode_tag);
    longint lo, hi, a, t;
    int units, p;
    lo = longint'(m_reg[15:0]) * 65536;
    hi = lo + (longint'(m_reg[23:20]) + 1) * 65536;
    a  = longint'(req_addr);
    t  = longint'(tom_limit);
    hit = m_reg[27] && (a >= lo) && (a < hi) && (hi <= t);
    ill = m_reg[26] && m_reg[25];
    if (!hit) begin
      dram = (a < t);
      mode_tag = m_reg[27] ? "R7" : "R13";
    end else if (ill) begin
      dram = 1'b0; mode_tag = "R11";
    end else if (m_reg[26]) begin
      dram = 1'b1; mode_tag = "R10";
    end else if (m_reg[25]) begin
      dram = req_smm && req_code; mode_tag = "R9";
    end else begin
      dram = req_smm; mode_tag = "R8";
    end
    units = int'(m_reg[23:20]) + 1;
    p = 1;
    while (p < units) p = p * 2;
    mis = (int'(m_reg[15:0]) % p) != 0;
  endtask

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit h, d, il, mi;
      string mt;
      model_route(h, d, il, mi, mt);
      check(m_reg[27] ? "R6" : "R13", "model hit", rsp_hit, h);
      check(mt, "model route", rsp_dram, d);
      check("R11", "model illegal", cfg_illegal, il);
      check("R12", "model misalign", cfg_misalign, mi);
      check("R2", "model read data", cfg_rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_be = be; cfg_wr_data = d;
    step();
    cfg_wr_en = 1'b0; cfg_wr_be = '0; cfg_wr_data = '0;
  endtask

  task automatic rd_chk(input logic [31:0] exp, input string tag);
    cfg_rd_en = 1'b1;
    step();
    cfg_rd_en = 1'b0;
    @(negedge clk);
    check(tag, "read word", cfg_rd_data, exp);
    step();
  endtask

  task automatic req_chk(input logic [31:0] a, input bit code, input bit smm,
                         input bit e_hit, input bit e_dram, input bit e_ill,
                         input bit e_mis, input string tag);
    req_addr = a; req_code = code; req_smm = smm;
    @(negedge clk);
    check(tag, "hit", rsp_hit, e_hit);
    check(tag, "dram", rsp_dram, e_dram);
    check(tag, "illegal", cfg_illegal, e_ill);
    check(tag, "misalign", cfg_misalign, e_mis);
    step();
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();

    // R1 reset word; R13 disabled window, ordinary route
    rd_chk(32'h0000_000A, "R1");
    req_chk(32'h000A_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R13");
    req_chk(32'h1000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R13");

    // R2/R3: lane 2 only, reserved nibble stays zero
    wr(4'b0100, 32'hFFFF_FFFF);
    rd_chk(32'h00F0_000A, "R2");
    wr(4'b0011, 32'hFFFF_0010);
    rd_chk(32'h00F0_0010, "R3");
    wr(4'b0100, 32'h0000_0000);
    wr(4'b1000, 32'h0800_0000);
    rd_chk(32'h0800_0010, "R3");

    // R8 closed window: management mode decides; R6 edges
    req_chk(32'h0010_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    req_chk(32'h0010_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    req_chk(32'h000F_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    req_chk(32'h0010_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    req_chk(32'h0011_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");

    // R9 code-only mode
    wr(4'b1000, 32'h0A00_0000);
    req_chk(32'h0010_8000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    req_chk(32'h0010_8000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    req_chk(32'h0010_8000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

    // R10 open window
    wr(4'b1000, 32'h0C00_0000);
    rd_chk(32'h0C00_0010, "R10");
    req_chk(32'h0010_8000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10");

    // R11 contradictory controls
    wr(4'b1000, 32'h0E00_0000);
    req_chk(32'h0010_8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R11");
    req_chk(32'h0020_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");

    // R12 alignment: size code 2 (three units, align four)
    wr(4'b1000, 32'h0C00_0000);
    wr(4'b0111, 32'h0020_000A);
    req_chk(32'h000A_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R12");
    wr(4'b0011, 32'h0000_000C);
    req_chk(32'h000E_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R12");
    req_chk(32'h000F_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");

    // R6/R7 top-of-memory clips the window
    tom_limit = 32'h000E_0000;
    req_chk(32'h000C_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    req_chk(32'h000E_8000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    tom_limit = 32'h1000_0000;

    // R6 largest size code: 1 MB window at 1 MB
    wr(4'b0111, 32'h00F0_0010);
    req_chk(32'h001F_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    req_chk(32'h0020_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    wr(4'b0011, 32'h0000_0018);
    req_chk(32'h0018_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R12");
    wr(4'b0011, 32'h0000_0010);

    // R4 lock write closes the window even with open requested
    wr(4'b1000, 32'h0D00_0000);
    rd_chk(32'h09F0_0010, "R4");
    // R5 lock and open frozen, other fields writable
    wr(4'b1000, 32'h0400_0000);
    rd_chk(32'h01F0_0010, "R5");
    wr(4'b0100, 32'h0030_0000);
    rd_chk(32'h0130_0010, "R5");
    wr(4'b1000, 32'h0C00_0000);
    rd_chk(32'h0930_0010, "R5");
    req_chk(32'h0010_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");

    // R5 only reset releases the lock
    #3 rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    rd_chk(32'h0000_000A, "R1");
    wr(4'b1000, 32'h0400_0000);
    rd_chk(32'h0400_000A, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule